// File: doc/BRIEF.md
# Serial Flash Status-Register Write Controller

This block is the slave-side command logic for the status register of a serial flash device. A host talks to it over a four-wire SPI link made of an active-low select, a serial clock, a data input and a data output. The link runs in mode 0 with the most significant bit first. The block decodes three one-byte instructions: write enable, write status and read status. It keeps the status byte, and it decides whether a status write may be committed. That decision depends on the write-enable latch and on a hardware write-protect input.

Every SPI input is brought into the system clock domain through a synchronizer of configurable depth, and each edge is then detected there. A committed status write starts a self-timed busy period that is counted in system clocks. While that period runs, the status byte can still be read, so the host can poll the busy flag. When the period ends, the write-enable latch clears. The block exports the three block-protect bits and a flag that shows when the status register is locked by hardware, so that array-side logic can apply the protection.

Top module: `spi_sr_wr_ctrl`

## Requirements
- R1: After reset, the status byte reads 0x00, the block-protect outputs are 0, the hardware-lock flag is 0 and the serial output is 0.
- R2: Opcode 0x05 (read status) makes the block drive the status byte on the serial output, MSB first. Each bit is changed on a falling serial clock edge, so the first bit is valid before the rising edge that follows the opcode. The byte repeats for as long as select stays low. The status byte has this layout: bit 7 is the write-disable bit, bits 6 and 5 are 0, bits 4..2 are the block-protect field, bit 1 is the write-enable latch and bit 0 is the busy flag.
- R3: Opcode 0x06 (write enable) sets the write-enable latch only when select rises after exactly 8 clock bits. A frame of any other length leaves the latch unchanged.
- R4: Opcode 0x01 (write status) followed by a data byte loads data bit 7 into the write-disable bit and data bits 4..2 into the block-protect field. Data bits 6, 5, 1 and 0 have no effect, and status bits 6 and 5 always read 0.
- R5: A write-status frame is discarded unless select rises after exactly 16 clock bits. A discarded frame changes no status bit.
- R6: A write-status frame is rejected when the write-enable latch is 0. It then changes no bit and does not start a busy period.
- R7: A committed write sets the busy flag for BUSY_CYCLES system clocks. The write-enable latch stays 1 during this period and is cleared in the same cycle that the busy flag clears.
- R8: When the write-disable bit is 1 and the write-protect input is low, write-status frames are rejected even with the latch set. The latch stays 1, no busy period starts, and the register is locked whichever of the two conditions arose first.
- R9: A write-status frame with the latch set is accepted when the write-disable bit is 0, at any level of the write-protect input. It is also accepted when the write-protect input is high.
- R10: While the busy flag is 1, write-enable and write-status frames are ignored, and read-status frames still work.
- R11: The block-protect outputs always equal status bits 4..2. The hardware-lock output is 1 exactly when the write-disable bit is 1 and the synchronized write-protect input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | SPI select, active low |
| spi_sck | input | 1 | SPI serial clock (mode 0) |
| spi_mosi | input | 1 | SPI data from host |
| wp_n | input | 1 | Write-protect input, active low |
| spi_miso | output | 1 | SPI data to host, driven 0 outside a status read |
| blk_prot | output | 3 | Block-protect field of the status byte |
| hw_locked | output | 1 | Status register locked by hardware |

## Verification
The assertions check these properties on every cycle:
- A busy period never outlasts BUSY_CYCLES clocks.
- A busy period only starts while the latch is set, and the latch is clear once the busy flag falls.
- The protection bits hold still while the hardware lock or a busy period is in effect.
- The serial output stays quiet with select high.

Only the bench scenarios can show the frame-level rules: the exact bit counts for write enable and write status, that the ignored data bits have no effect, the order in which lock conditions are entered, and the serial ordering of a repeated status read. The bench follows these with a reference model under random instruction mixes.

// File: rtl/swc_pkg.sv
package swc_pkg;
   localparam logic [7:0] OP_WREN = 8'h06;
   localparam logic [7:0] OP_WRSR = 8'h01;
   localparam logic [7:0] OP_RDSR = 8'h05;

   localparam int SR_WIP  = 0;
   localparam int SR_WEL  = 1;
   localparam int SR_BP_LO = 2;
   localparam int SR_BP_HI = 4;
   localparam int SR_SRWD = 7;

   localparam int BP_W = SR_BP_HI - SR_BP_LO + 1;

   localparam int WREN_BITS = 8;
   localparam int WRSR_BITS = 16;
endpackage

// File: rtl/swc_sync.sv
module swc_sync #(
   parameter int         W       = 1,
   parameter int         STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("swc_sync: W must be at least 1");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] stage_q [STAGES];
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= RST_VAL;
               else        stage_q[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= RST_VAL;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
      assign q = stage_q[STAGES-1];
   end
endmodule

// File: rtl/swc_rx.sv
module swc_rx #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_s,
   input  logic             sck_s,
   input  logic             mosi_s,
   output logic             frame_end,
   output logic             sck_fall,
   output logic [CNT_W-1:0] bit_cnt,
   output logic [2:0]       bit_pos,
   output logic             op_valid,
   output logic [7:0]       op_code,
   output logic [7:0]       last_byte
);
   localparam logic [CNT_W-1:0] CNT_MAX  = '1;
   localparam logic [CNT_W-1:0] CNT_OPND = CNT_W'(7);

   logic sck_q, cs_q, sck_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0;
         cs_q  <= 1'b1;
      end else begin
         sck_q <= sck_s;
         cs_q  <= cs_s;
      end
   end

   assign sck_rise  = sck_s & ~sck_q & ~cs_s;
   assign sck_fall  = ~sck_s & sck_q & ~cs_s;
   assign frame_end = cs_s & ~cs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt   <= '0;
         bit_pos   <= '0;
         op_valid  <= 1'b0;
         op_code   <= '0;
         last_byte <= '0;
      end else if (cs_s) begin
         bit_cnt  <= '0;
         bit_pos  <= '0;
         op_valid <= 1'b0;
      end else if (sck_rise) begin
         last_byte <= {last_byte[6:0], mosi_s};
         bit_pos   <= bit_pos + 3'd1;
         if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
         if (bit_cnt == CNT_OPND) begin
            op_code  <= {last_byte[6:0], mosi_s};
            op_valid <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/swc_tx.sv
module swc_tx (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       active,
   input  logic       sck_fall,
   input  logic [2:0] bit_pos,
   input  logic [7:0] status,
   output logic       miso
);
   logic [6:0] rest_q;
   logic       out_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rest_q <= '0;
         out_q  <= 1'b0;
      end else if (!active) begin
         rest_q <= '0;
         out_q  <= 1'b0;
      end else if (sck_fall) begin
         if (bit_pos == 3'd0) begin
            out_q  <= status[7];
            rest_q <= status[6:0];
         end else begin
            out_q  <= rest_q[6];
            rest_q <= {rest_q[5:0], 1'b0};
         end
      end
   end

   assign miso = out_q;
endmodule

// File: rtl/swc_busy.sv
module swc_busy #(
   parameter int CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
   localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

   logic [CW-1:0] left_q;

   assign done = busy & (left_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         left_q <= '0;
      end else if (start && !busy) begin
         busy   <= 1'b1;
         left_q <= LOAD;
      end else if (done) begin
         busy <= 1'b0;
      end else if (busy) begin
         left_q <= left_q - 1'b1;
      end
   end
endmodule

// File: rtl/spi_sr_wr_ctrl.sv
module spi_sr_wr_ctrl
   import swc_pkg::*;
#(
   parameter int BUSY_CYCLES = 1000,
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            spi_cs_n,
   input  logic            spi_sck,
   input  logic            spi_mosi,
   input  logic            wp_n,
   output logic            spi_miso,
   output logic [BP_W-1:0] blk_prot,
   output logic            hw_locked
);
   if (BUSY_CYCLES < 1) begin : g_bad_busy
      $error("spi_sr_wr_ctrl: BUSY_CYCLES must be at least 1");
   end
   if ((1 << CNT_W) <= WRSR_BITS + 1) begin : g_bad_cnt
      $error("spi_sr_wr_ctrl: CNT_W too small to count a write-status frame");
   end

   localparam logic [CNT_W-1:0] N_WREN = CNT_W'(WREN_BITS);
   localparam logic [CNT_W-1:0] N_WRSR = CNT_W'(WRSR_BITS);

   logic cs_s, sck_s, mosi_s, wp_s;

   swc_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({spi_cs_n, spi_sck, spi_mosi, wp_n}),
      .q     ({cs_s, sck_s, mosi_s, wp_s})
   );

   logic             frame_end, sck_fall, op_valid;
   logic [CNT_W-1:0] bit_cnt;
   logic [2:0]       bit_pos;
   logic [7:0]       op_code, data_byte;

   swc_rx #(.CNT_W(CNT_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_s      (cs_s),
      .sck_s     (sck_s),
      .mosi_s    (mosi_s),
      .frame_end (frame_end),
      .sck_fall  (sck_fall),
      .bit_cnt   (bit_cnt),
      .bit_pos   (bit_pos),
      .op_valid  (op_valid),
      .op_code   (op_code),
      .last_byte (data_byte)
   );

   logic            srwd_q, wel_q, wip;
   logic [BP_W-1:0] bp_q;
   logic            busy_done, hw_prot;
   logic            do_wren, wrsr_frame, do_commit;
   logic [7:0]      status_rd;

   assign hw_prot = srwd_q & ~wp_s;

   always_comb begin
      status_rd                  = '0;
      status_rd[SR_SRWD]         = srwd_q;
      status_rd[SR_BP_HI:SR_BP_LO] = bp_q;
      status_rd[SR_WEL]          = wel_q;
      status_rd[SR_WIP]          = wip;
   end

   assign do_wren    = frame_end & op_valid & (op_code == OP_WREN)
                     & (bit_cnt == N_WREN) & ~wip;
   assign wrsr_frame = frame_end & op_valid & (op_code == OP_WRSR)
                     & (bit_cnt == N_WRSR) & ~wip;
   assign do_commit  = wrsr_frame & wel_q & ~hw_prot;

   logic unused_data_bits;
   assign unused_data_bits = ^{data_byte[6:5], data_byte[1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         srwd_q <= 1'b0;
         bp_q   <= '0;
         wel_q  <= 1'b0;
      end else begin
         if (do_commit) begin
            srwd_q <= data_byte[SR_SRWD];
            bp_q   <= data_byte[SR_BP_HI:SR_BP_LO];
         end
         if (busy_done)    wel_q <= 1'b0;
         else if (do_wren) wel_q <= 1'b1;
      end
   end

   swc_busy #(.CYCLES(BUSY_CYCLES)) u_busy (
      .clk   (clk),
      .rst_n (rst_n),
      .start (do_commit),
      .busy  (wip),
      .done  (busy_done)
   );

   swc_tx u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (op_valid & (op_code == OP_RDSR)),
      .sck_fall (sck_fall),
      .bit_pos  (bit_pos),
      .status   (status_rd),
      .miso     (spi_miso)
   );

   assign blk_prot  = bp_q;
   assign hw_locked = hw_prot;
endmodule

// File: rtl/swc_chk.sv
module swc_chk #(
   parameter int BUSY_CYCLES = 1000
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_s,
   input logic       wip,
   input logic       wel,
   input logic       srwd,
   input logic [2:0] bp,
   input logic       hw_prot,
   input logic       miso
);
   int unsigned wip_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   wip_run <= 0;
      else if (!wip) wip_run <= 0;
      else          wip_run <= wip_run + 1;
   end

   // R7
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wip_run <= BUSY_CYCLES);

   // R7
   wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wip) |-> !wel);

   // R6
   busy_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wip) |-> wel);

   // R8
   hw_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(hw_prot) |-> $stable({srwd, bp}));

   // R10
   busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wip) && wip) |-> $stable({srwd, bp}));

   // R2
   miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_s && $past(cs_s) && $past(cs_s, 2)) |-> !miso);
endmodule

bind spi_sr_wr_ctrl swc_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cs_s    (cs_s),
   .wip     (wip),
   .wel     (wel_q),
   .srwd    (srwd_q),
   .bp      (bp_q),
   .hw_prot (hw_prot),
   .miso    (spi_miso)
);

// File: tb/tb_spi_sr_wr_ctrl.sv
module tb_spi_sr_wr_ctrl;
   localparam int BUSY = 1000;
   localparam int HP   = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1;
   logic       miso, hwl;
   logic [2:0] bp;

   always #10 clk = ~clk;

   spi_sr_wr_ctrl #(.BUSY_CYCLES(BUSY), .SYNC_STAGES(2), .CNT_W(5)) dut (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck),
      .spi_mosi(mosi), .wp_n(wp_n), .spi_miso(miso),
      .blk_prot(bp), .hw_locked(hwl)
   );

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   logic       m_srwd = 0, m_wel = 0;
   logic [2:0] m_bp = 0;

   function automatic logic [7:0] exp_sr(input logic wip);
      return {m_srwd, 2'b00, m_bp, m_wel, wip};
   endfunction

   function automatic logic exp_lock();
      return m_srwd & ~wp_n;
   endfunction

   function automatic logic accepts();
      return m_wel & ~(m_srwd & ~wp_n);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic spi_begin();
      cs_n = 1'b0;
      wclk(HP);
   endtask

   task automatic spi_end();
      wclk(HP);
      cs_n = 1'b1;
      mosi = 1'b0;
      wclk(4 * HP);
   endtask

   task automatic spi_bit(input logic b, output logic r);
      mosi = b;
      wclk(HP);
      r = miso;
      sck = 1'b1;
      wclk(HP);
      sck = 1'b0;
   endtask

   task automatic spi_frame(input logic [31:0] tx, input int nbits, output logic [7:0] rx);
      logic r;
      rx = '0;
      spi_begin();
      for (int i = 0; i < nbits; i++) begin
         spi_bit(tx[31 - i], r);
         rx = {rx[6:0], r};
      end
      spi_end();
   endtask

   task automatic read_sr(output logic [7:0] s);
      spi_frame({8'h05, 24'h0}, 16, s);
   endtask

   task automatic send_wren(input int nbits);
      logic [7:0] d;
      spi_frame({8'h06, 24'h0}, nbits, d);
   endtask

   task automatic send_wrsr(input logic [7:0] v, input int nbits);
      logic [7:0] d;
      spi_frame({8'h01, v, 16'h0}, nbits, d);
   endtask

   // one frame: opcode, then status bytes until busy clears or limit
   task automatic read_until_idle(input int max_bytes, output logic [7:0] last, output int nbytes);
      logic r;
      spi_begin();
      for (int i = 0; i < 8; i++) spi_bit(8'h05 >> (7 - i), r);
      nbytes = 0;
      last = 8'hFF;
      for (int k = 0; k < max_bytes; k++) begin
         for (int i = 0; i < 8; i++) begin
            spi_bit(1'b0, r);
            last = {last[6:0], r};
         end
         nbytes++;
         if (!last[0]) break;
      end
      spi_end();
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] s, s2;
      logic [7:0] v;
      int nb, op, nbits;
      void'($urandom(32'h5EED_1234));

      wclk(5);
      rst_n = 1'b1;
      wclk(5);
      // R1 reset state
      check("R1 miso", miso, 0);
      check("R1 blk_prot", bp, 0);
      check("R1 hw_locked", hwl, 0);
      read_sr(s);
      check("R1 status", s, 8'h00);

      // R6 write without latch
      send_wrsr(8'h9C, 16);
      read_sr(s);
      check("R6 no latch", s, 8'h00);

      // R3 wrong-length enable, then exact
      send_wren(9);
      read_sr(s);
      check("R3 9-bit enable", s, 8'h00);
      send_wren(8);
      read_sr(s);
      check("R3 enable", s, 8'h02);

      // R5 wrong-length writes
      send_wrsr(8'hFF, 15);
      read_sr(s);
      check("R5 15 bits", s, 8'h02);
      send_wrsr(8'hFF, 17);
      read_sr(s);
      check("R5 17 bits", s, 8'h02);

      // R4 R7 R10 committed write, busy timing, ignored write while busy
      send_wrsr(8'hFF, 16);
      read_sr(s);
      check("R4 R7 busy start", s, 8'h9F);
      send_wrsr(8'h00, 16);
      read_sr(s);
      check("R7 still busy", s, 8'h9F);
      read_sr(s);
      check("R10 R7 after busy", s, 8'h9C);
      check("R11 blk_prot", bp, 3'b111);
      m_srwd = 1; m_bp = 3'b111; m_wel = 0;

      // R8 lock: latch set, write-protect low
      wp_n = 1'b0;
      wclk(10);
      check("R11 lock flag", hwl, 1);
      send_wren(8);
      send_wrsr(8'h00, 16);
      read_sr(s);
      check("R8 rejected", s, 8'h9E);

      // R9 unlock by pin high
      wp_n = 1'b1;
      wclk(10);
      check("R11 unlock flag", hwl, 0);
      send_wrsr(8'h04, 16);
      read_until_idle(40, s, nb);
      check("R9 pin high", s, 8'h04);
      check("R11 blk_prot 001", bp, 3'b001);

      // R9 pin low with write-disable 0, then R8 lock entered in other order
      wp_n = 1'b0;
      wclk(10);
      check("R11 no lock srwd0", hwl, 0);
      send_wren(8);
      send_wrsr(8'h88, 16);
      read_until_idle(40, s, nb);
      check("R9 pin low srwd0", s, 8'h88);
      check("R8 lock after srwd", hwl, 1);

      // R2 repeated read in one frame
      begin
         logic r;
         spi_begin();
         for (int i = 0; i < 8; i++) spi_bit(8'h05 >> (7 - i), r);
         for (int k = 0; k < 3; k++) begin
            s2 = '0;
            for (int i = 0; i < 8; i++) begin
               spi_bit(1'b0, r);
               s2 = {s2[6:0], r};
            end
            check("R2 repeat byte", s2, 8'h88);
         end
         spi_end();
      end

      // return to a known state for random phase
      wp_n = 1'b1;
      wclk(10);
      send_wren(8);
      send_wrsr(8'h00, 16);
      read_until_idle(40, s, nb);
      m_srwd = 0; m_bp = 0; m_wel = 0;
      check("R4 cleared", s, 8'h00);

      for (int it = 0; it < 30; it++) begin
         op = $urandom_range(0, 5);
         case (op)
            0: begin
               send_wren(8);
               m_wel = 1;
            end
            1: begin
               v = 8'($urandom);
               send_wrsr(v, 16);
               if (accepts()) begin
                  read_until_idle(40, s, nb);
                  m_srwd = v[7];
                  m_bp = v[4:2];
                  m_wel = 0;
               end
            end
            2: begin
               nbits = $urandom_range(9, 20);
               if (nbits == 16) nbits = 20;
               send_wrsr(8'($urandom), nbits);
            end
            3: begin
               wp_n = $urandom_range(0, 1);
               wclk(10);
            end
            4: begin
               send_wren($urandom_range(0, 1) ? 7 : 9);
            end
            default: ;
         endcase
         read_sr(s);
         check("R4 R5 R6 R8 R9 random status", s, exp_sr(1'b0));
         check("R11 random blk_prot", bp, m_bp);
         check("R11 random lock", hwl, exp_lock());
      end

      finished = 1;
      summary();
      $finish;
   end
endmodule